// File: doc/BRIEF.md
# Multiplexed-Address Dynamic RAM Front-End Model

This block is a cycle-level, synthesizable stand-in for a 16384 x 1 dynamic RAM. It is placed next to a memory controller under test. Every input is sampled on the system clock. A row address is taken when the row strobe falls and a column address when the column strobe falls, both over one shared 7-bit address bus. The model stores one bit per cell.

The model supports the following access types:
- Plain reads and early writes.
- Read-modify-write, where the write enable falls after the column strobe.
- Page-mode access to several columns of one open row.
- Row-strobe-only refresh.
- Hidden refresh, where the row strobe cycles while the column strobe holds the read data.

The output-enable flag stands in for a three-state driver and follows the column strobe only.

Each row keeps a refresh age in clocks. Any row-strobe activation of a row clears its age. Reading a row that had passed the refresh limit when it was opened sets a sticky decay error. A column strobe that falls with no row open is ignored and sets a sticky protocol error.

Top module: `dram_front_model`

## Requirements
- R1: After reset, `dout_en`, `decay_err` and `proto_err` are all 0.
- R2: The cell index is row*128 + column. The row is taken from `addr` in the clock where `ras_n` is first sampled low, and the column in the clock where `cas_n` is first sampled low. A read (`we_n` high at that clock) drives the stored bit on `dout` with `dout_en` = 1 from the following clock.
- R3: If `we_n` is low in the clock where `cas_n` falls with a row open, the cell takes `din` and `dout_en` stays 0.
- R4: In the clock after `cas_n` is sampled high following an access, `dout_en` is 0.
- R5: While `cas_n` stays low after a read, cycling `ras_n` with other row addresses leaves `dout` and `dout_en` unchanged.
- R6: A `ras_n` cycle with `cas_n` high produces no output and changes no stored bit.
- R7: A write changes only the addressed bit. Other bits of the same row keep their values.
- R8: With `ras_n` held low, successive `cas_n` cycles with new columns read and write different bits of the open row.
- R9: If `we_n` falls while `cas_n` is low during a read, `din` is written to the accessed cell, and `dout` keeps the old value with `dout_en` = 1.
- R10: Opening a row whose age exceeds `REFRESH_LIMIT` clocks and then reading it sets `decay_err`, which stays set. Opening a row clears its age, so a row opened within the limit reads without error.
- R11: A `cas_n` fall while no row is open performs no access, leaves `dout_en` at 0, and sets `proto_err`, which stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 7 | Multiplexed row/column address |
| din | input | 1 | Write data |
| dout | output | 1 | Read data |
| dout_en | output | 1 | High when the data output would be driven |
| decay_err | output | 1 | Sticky: a row past its refresh limit was read |
| proto_err | output | 1 | Sticky: column strobe fell with no row open |

## Verification
The bench writes transposed cell pairs such as (3,5) and (5,3). A model that swapped row and column would read them back crossed.

It releases the row strobe and reopens it on other rows while the column strobe holds read data. A model whose output followed the row strobe would drop `dout_en` there.

It drops the write enable in the middle of a read to catch a model that overwrites `dout` or misses the late write. It also lets rows go stale and then refreshes one without a read. A model that checked age after clearing it, or that flagged refreshes, would report decay wrongly, either missing it or raising it.

// File: rtl/dram_model_pkg.sv
package dram_model_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  // Saturating age increment: stops one past the limit.
  function automatic int unsigned age_step(input int unsigned age, input int unsigned lim);
    return (age > lim) ? age : age + 1;
  endfunction

  function automatic logic age_expired(input int unsigned age, input int unsigned lim);
    return age > lim;
  endfunction

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] fall,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '1;
    else        prev <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign fall[i] = prev[i] & ~lvl[i];
    assign rise[i] = ~prev[i] & lvl[i];
  end
endmodule

// File: rtl/cell_array.sv
module cell_array #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_row,
  input  logic [ADDR_W-1:0] wr_col,
  input  logic              wr_bit,
  input  logic [ADDR_W-1:0] rd_row,
  input  logic [ADDR_W-1:0] rd_col,
  output logic              rd_bit
);
  localparam int ROWS = 1 << ADDR_W;
  localparam int COLS = 1 << ADDR_W;

  // One entry per row, each a full row of bits.
  logic [COLS-1:0] rows [ROWS];

  always_ff @(posedge clk) begin
    if (wr_en) rows[wr_row][wr_col] <= wr_bit;
  end

  assign rd_bit = rows[rd_row][rd_col];
endmodule

// File: rtl/refresh_age_tracker.sv
module refresh_age_tracker
  import dram_model_pkg::*;
#(
  parameter int          ADDR_W = 7,
  parameter int unsigned LIMIT  = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_en,
  input  logic [ADDR_W-1:0] clear_row,
  input  logic [ADDR_W-1:0] sel_row,
  output logic              stale_o
);
  localparam int ROWS  = 1 << ADDR_W;
  localparam int AGE_W = $clog2(LIMIT + 2);

  logic [ROWS-1:0] stale_vec;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [AGE_W-1:0] age;
    always_ff @(posedge clk) begin
      if (!rst_n)
        age <= '0;
      else if (clear_en && clear_row == ADDR_W'(r))
        age <= '0;
      else
        age <= AGE_W'(age_step(32'(age), LIMIT));
    end
    assign stale_vec[r] = age_expired(32'(age), LIMIT);
  end

  assign stale_o = stale_vec[sel_row];

  // R10: an activated row is fresh right after its activation
  assert_age_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear_en |=> !stale_vec[$past(clear_row)]);
endmodule

// File: rtl/dram_front_model.sv
module dram_front_model
  import dram_model_pkg::*;
#(
  parameter int          ADDR_W        = 7,
  parameter int unsigned REFRESH_LIMIT = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic              dout,
  output logic              dout_en,
  output logic              decay_err,
  output logic              proto_err
);
  // Strobe events, brought out as named wires.
  logic [1:0] st_fall, st_rise;
  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall, we_q;

  strobe_edge #(.N(2)) u_edges (
    .clk (clk), .rst_n (rst_n), .lvl ({cas_n, ras_n}),
    .fall(st_fall), .rise (st_rise)
  );
  assign ras_fall = st_fall[0];
  assign ras_rise = st_rise[0];
  assign cas_fall = st_fall[1];
  assign cas_rise = st_rise[1];

  always_ff @(posedge clk) begin
    if (!rst_n) we_q <= 1'b1;
    else        we_q <= we_n;
  end
  assign we_fall = we_q & ~we_n;

  logic              row_open, row_stale;
  logic [ADDR_W-1:0] open_row, acc_row, acc_col;
  acc_e              acc_state;

  // Write port: early write at column strobe, or late write in a read.
  logic              early_wr, late_wr, wr_en, rd_bit, stale_sel;
  logic [ADDR_W-1:0] wr_row, wr_col;

  assign early_wr = cas_fall && row_open && !we_n;
  assign late_wr  = we_fall && !cas_n && !cas_rise && acc_state == ACC_READ;
  assign wr_en    = early_wr || late_wr;
  assign wr_row   = early_wr ? open_row : acc_row;
  assign wr_col   = early_wr ? addr     : acc_col;

  cell_array #(.ADDR_W(ADDR_W)) u_cells (
    .clk   (clk),     .wr_en (wr_en),    .wr_row(wr_row),
    .wr_col(wr_col),  .wr_bit(din),      .rd_row(open_row),
    .rd_col(addr),    .rd_bit(rd_bit)
  );

  refresh_age_tracker #(.ADDR_W(ADDR_W), .LIMIT(REFRESH_LIMIT)) u_age (
    .clk      (clk),      .rst_n    (rst_n),
    .clear_en (ras_fall), .clear_row(addr),
    .sel_row  (addr),     .stale_o  (stale_sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_open  <= 1'b0;
      row_stale <= 1'b0;
      open_row  <= '0;
      acc_row   <= '0;
      acc_col   <= '0;
      acc_state <= ACC_IDLE;
      dout      <= 1'b0;
      dout_en   <= 1'b0;
      decay_err <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      if (ras_fall) begin
        open_row  <= addr;
        row_open  <= 1'b1;
        row_stale <= stale_sel;   // age seen before this activation clears it
      end else if (ras_rise) begin
        row_open  <= 1'b0;
      end

      if (cas_rise) begin
        acc_state <= ACC_IDLE;
        dout_en   <= 1'b0;
        dout      <= 1'b0;
      end else if (cas_fall) begin
        if (!row_open) begin
          proto_err <= 1'b1;
        end else begin
          acc_row <= open_row;
          acc_col <= addr;
          if (!we_n) begin
            acc_state <= ACC_WRITE;
          end else begin
            acc_state <= ACC_READ;
            dout      <= rd_bit;
            dout_en   <= 1'b1;
            if (row_stale) decay_err <= 1'b1;
          end
        end
      end else if (late_wr) begin
        acc_state <= ACC_WRITE;   // output keeps the old data
      end
    end
  end

  // R3: early write leaves the output off
  assert_early_write_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    early_wr |=> !dout_en);
  // R4: column strobe high releases the output
  assert_release_on_cas_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cas_rise |=> !dout_en);
  // R5: held column strobe keeps output and data stable
  assert_hold_under_cas_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && !cas_n) |=> (dout_en && $stable(dout)));
  // R10: decay flag is sticky
  assert_decay_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    decay_err |=> decay_err);
  // R11: orphan column strobe flags and stays flagged
  assert_orphan_cas_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_fall && !row_open) |=> proto_err);
  assert_proto_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
endmodule

// File: tb/tb_dram_front_model.sv
module tb_dram_front_model;
  localparam int          AW    = 7;
  localparam int unsigned LIMIT = 2000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
  logic [AW-1:0] addr = '0;
  logic dout, dout_en, decay_err, proto_err;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dram_front_model #(.ADDR_W(AW), .REFRESH_LIMIT(LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .decay_err(decay_err), .proto_err(proto_err)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic ras_open(input int row);
    addr = AW'(row); ras_n = 1'b0; tick();
  endtask
  task automatic ras_close();
    ras_n = 1'b1; tick();
  endtask
  task automatic cas_read(input int col);
    we_n = 1'b1; addr = AW'(col); cas_n = 1'b0; tick();
  endtask
  task automatic cas_end();
    cas_n = 1'b1; we_n = 1'b1; tick();
  endtask
  task automatic cas_write(input int col, input logic b);
    we_n = 1'b0; din = b; addr = AW'(col); cas_n = 1'b0; tick();
    chk("R3 output off in early write", dout_en, 1'b0);
    cas_end();
  endtask
  task automatic write_cell(input int row, input int col, input logic b);
    ras_open(row); cas_write(col, b); ras_close();
  endtask
  task automatic read_cell(input int row, input int col, input logic exp, input string req);
    ras_open(row); cas_read(col);
    chk({req, " dout_en"}, dout_en, 1'b1);
    chk({req, " data"}, dout, exp);
    cas_end();
    chk("R4 release", dout_en, 1'b0);
    ras_close();
  endtask

  task automatic t_reset();
    chk("R1 dout_en", dout_en, 1'b0);
    chk("R1 decay_err", decay_err, 1'b0);
    chk("R1 proto_err", proto_err, 1'b0);
  endtask

  task automatic t_index();   // R2: index = row*128+col
    write_cell(3, 5, 1'b1); write_cell(5, 3, 1'b0);
    write_cell(127, 127, 1'b1); write_cell(0, 0, 1'b0);
    read_cell(3, 5, 1'b1, "R2 (3,5)");
    read_cell(5, 3, 1'b0, "R2 (5,3)");
    read_cell(127, 127, 1'b1, "R2 (127,127)");
    read_cell(0, 0, 1'b0, "R2 (0,0)");
  endtask

  task automatic t_row_keep();  // R7
    write_cell(3, 4, 1'b0); write_cell(3, 6, 1'b0);
    write_cell(3, 6, 1'b1);
    read_cell(3, 4, 1'b0, "R7 neighbour col4");
    read_cell(3, 5, 1'b1, "R7 neighbour col5");
    read_cell(3, 6, 1'b1, "R7 target col6");
  endtask

  task automatic t_page();  // R8
    ras_open(3);
    cas_read(4); chk("R8 page col4", dout, 1'b0); cas_end();
    cas_read(5); chk("R8 page col5", dout, 1'b1); cas_end();
    cas_write(4, 1'b1);
    cas_read(4); chk("R8 page write col4", dout, 1'b1);
    chk("R8 page dout_en", dout_en, 1'b1); cas_end();
    ras_close();
  endtask

  task automatic t_rmw();  // R9
    write_cell(10, 2, 1'b0);
    ras_open(10); cas_read(2);
    we_n = 1'b0; din = 1'b1; tick();
    chk("R9 old data held", dout, 1'b0);
    chk("R9 output on", dout_en, 1'b1);
    cas_end(); ras_close();
    read_cell(10, 2, 1'b1, "R9 late write stored");
  endtask

  task automatic t_hidden();  // R5
    ras_open(3); cas_read(5);
    ras_n = 1'b1; tick();
    ras_open(50);
    chk("R5 hold data row50", dout, 1'b1);
    chk("R5 hold en row50", dout_en, 1'b1);
    ras_n = 1'b1; tick();
    ras_open(60);
    chk("R5 hold data row60", dout, 1'b1);
    chk("R5 hold en row60", dout_en, 1'b1);
    cas_end();
    chk("R4 release after hidden", dout_en, 1'b0);
    ras_close();
  endtask

  task automatic t_ras_only();  // R6
    ras_open(3); tick(); tick();
    chk("R6 no output", dout_en, 1'b0);
    ras_close();
    read_cell(3, 5, 1'b1, "R6 data kept");
  endtask

  task automatic t_decay();  // R10
    chk("R10 no decay within limit", decay_err, 1'b0);
    for (int i = 0; i < int'(LIMIT) + 100; i++) tick();
    ras_open(3); tick(); ras_close();   // refresh only, no read
    chk("R10 refresh alone no flag", decay_err, 1'b0);
    read_cell(3, 5, 1'b1, "R10 refreshed row");
    chk("R10 refreshed row no flag", decay_err, 1'b0);
    read_cell(127, 127, 1'b1, "R10 stale row read");
    chk("R10 stale read flags", decay_err, 1'b1);
    read_cell(3, 5, 1'b1, "R10 later read");
    chk("R10 sticky", decay_err, 1'b1);
  endtask

  task automatic t_orphan();  // R11
    ras_n = 1'b1;
    we_n = 1'b0; din = 1'b0; addr = AW'(127); cas_n = 1'b0; tick();
    chk("R11 no output", dout_en, 1'b0);
    chk("R11 flag set", proto_err, 1'b1);
    cas_end();
    cas_read(5);
    chk("R11 orphan read no output", dout_en, 1'b0);
    cas_end();
    read_cell(127, 127, 1'b1, "R11 no write");
    chk("R11 sticky", proto_err, 1'b1);
  endtask

  initial begin
    repeat (4) tick();
    rst_n = 1'b1; tick();
    t_reset();
    t_index();
    t_row_keep();
    t_page();
    t_rmw();
    t_hidden();
    t_ras_only();
    t_decay();
    t_orphan();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule